// File: doc/BRIEF.md
# Ten-Channel DMA Request Arbiter

This block decides which of ten DMA channels may use the shared internal bus next. Every channel has an enable and a two-bit source select. The select picks the one event that can raise a request for that channel: a software trigger, a peripheral request line, a per-transfer cascade pulse from another channel, or an underflow cascade pulse from another channel. Requests are held in a pending flag per channel. An idle arbiter grants the pending channel with the lowest index, using a one-hot grant. The grant lasts for exactly one transfer. When the address and bus logic signals that the transfer is done, the grant drops, so arbitration is rerun before each transfer.

The same done event fires the cascade network. Ring chains are wired in fixed: 0 to 1 to 2 to 0, and 5 to 6 to 7 to 5. Single links are also fixed: 3 to 4, and 8 to 9. Channel 9's per-transfer targets come from a programmable mask. When the done transfer also reports a counter underflow, channel 0 requests channel 5, channel 3 requests channel 8, and channel 1 requests the channels in a second programmable mask. The cascade pulses are registered and leave the block as outputs. They can raise a request one cycle later.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant`, `casc_xfer_go`, `casc_uflow_go` and both target masks are all zero.
- R2: A channel becomes pending only when its `ch_en` bit is 1 and the event named by its `src_sel` field occurs. The field for channel i is `src_sel[2i+1:2i]`, with 0 = software trigger, 1 = peripheral request, 2 = per-transfer cascade pulse and 3 = underflow cascade pulse. Clearing `ch_en` drops that channel's pending request.
- R3: When no grant is active and at least one channel is pending, `grant` shows the lowest-index pending channel (one-hot) on the next cycle. A request raised at one clock edge is granted at the following edge at the earliest.
- R4: `grant` is at most one-hot. It stays unchanged until `xfer_done` is seen, and it is zero in the cycle after `xfer_done`.
- R5: `xfer_done` clears the pending flag of the granted channel. Repeated requests on a channel that is already pending merge into a single grant.
- R6: A request on the granted channel that arrives in the same cycle as its `xfer_done` is kept and is granted again.
- R7: In the cycle after `xfer_done`, `casc_xfer_go` shows the per-transfer targets of the channel that finished, for exactly one cycle. The targets are 0→1, 1→2, 2→0, 3→4, 5→6, 6→7, 7→5 and 8→9, with no target for channel 4.
- R8: When `xfer_uflow` is high together with `xfer_done`, `casc_uflow_go` shows the underflow targets for one cycle: 0→5, 3→8, and none for channels 2 and 4 to 9. Otherwise it stays zero.
- R9: The per-transfer targets of channel 9 and the underflow targets of channel 1 come from two masks. The masks are loaded from `mask_wdata` by `ring_mask_we` and `uf_mask_we` respectively.
- R10: A cascade pulse marks its target pending one cycle after the pulse, so that target is granted two cycles after the pulse. A channel may cascade to itself through the channel 9 mask.
- R11: `xfer_done` while no grant is active has no effect: no pulse and no pending change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 10 | Per-channel enable |
| src_sel | input | 20 | Two-bit request source per channel |
| sw_trig | input | 10 | Software trigger pulses |
| periph_req | input | 10 | Peripheral request lines |
| xfer_done | input | 1 | Granted transfer finished |
| xfer_uflow | input | 1 | Finished transfer underflowed its counter |
| ring_mask_we | input | 1 | Load channel 9 per-transfer target mask |
| uf_mask_we | input | 1 | Load channel 1 underflow target mask |
| mask_wdata | input | 10 | Mask load data |
| grant | output | 10 | One-hot bus grant |
| casc_xfer_go | output | 10 | Per-transfer cascade start pulses |
| casc_uflow_go | output | 10 | Underflow cascade start pulses |

## Verification
The clear caused by `xfer_done` and a new request on the same channel can land in the same cycle. The bench provokes this by pulsing the software trigger of the granted channel together with `xfer_done`, and it expects a second grant two edges later. A cascade pulse can also arrive on a channel whose select does not name it. The priority sweep drives this case on every pattern of simultaneous software requests, with all cascade targets on software select, and it checks that the grants come out in index order with no extra grant. A cycle-level model of the requirements follows a long random phase and judges the grant and both pulse outputs on every cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int unsigned DMA_NCH   = 10;
  localparam int unsigned DMA_SEL_W = 2;

  typedef enum logic [DMA_SEL_W-1:0] {
    SRC_SOFT   = 2'd0,
    SRC_PERIPH = 2'd1,
    SRC_XFER   = 2'd2,
    SRC_UFLOW  = 2'd3
  } src_sel_e;

  // Fixed per-transfer cascade links (channel 9 uses a programmable mask).
  function automatic logic [DMA_NCH-1:0] xfer_targets(input int unsigned ch);
    logic [DMA_NCH-1:0] t;
    t = '0;
    case (ch)
      0: t[1] = 1'b1;
      1: t[2] = 1'b1;
      2: t[0] = 1'b1;
      3: t[4] = 1'b1;
      5: t[6] = 1'b1;
      6: t[7] = 1'b1;
      7: t[5] = 1'b1;
      8: t[9] = 1'b1;
      default: t = '0;
    endcase
    return t;
  endfunction

  // Fixed underflow cascade links (channel 1 uses a programmable mask).
  function automatic logic [DMA_NCH-1:0] uflow_targets(input int unsigned ch);
    logic [DMA_NCH-1:0] t;
    t = '0;
    case (ch)
      0: t[5] = 1'b1;
      3: t[8] = 1'b1;
      default: t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/dma_src_mux.sv
module dma_src_mux
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH = DMA_NCH
) (
  input  logic [NCH-1:0]           ch_en,
  input  logic [DMA_SEL_W*NCH-1:0] src_sel,
  input  logic [NCH-1:0]           sw_trig,
  input  logic [NCH-1:0]           periph_req,
  input  logic [NCH-1:0]           casc_xf,
  input  logic [NCH-1:0]           casc_uf,
  output logic [NCH-1:0]           req
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    src_sel_e sel;
    logic     hit;
    assign sel = src_sel_e'(src_sel[DMA_SEL_W*c +: DMA_SEL_W]);
    always_comb begin
      case (sel)
        SRC_SOFT:   hit = sw_trig[c];
        SRC_PERIPH: hit = periph_req[c];
        SRC_XFER:   hit = casc_xf[c];
        default:    hit = casc_uf[c];
      endcase
    end
    assign req[c] = ch_en[c] & hit;
  end

endmodule

// File: rtl/dma_pend_latch.sv
module dma_pend_latch #(
  parameter int unsigned NCH = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] clr,
  input  logic [NCH-1:0] ch_en,
  output logic [NCH-1:0] pend
);

  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] pend_d;
  logic           pend_upd;

  always_comb begin
    pend_d   = ((pend_q & ~clr) | req) & ch_en;
    pend_upd = (pend_d != pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= '0;
    else if (pend_upd) pend_q <= pend_d;
  end

  assign pend = pend_q;

  // R2: a channel disabled at an edge holds no pending request afterwards
  a_r2_disabled_not_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_en != '1) |=> ((pend_q & ~$past(ch_en)) == '0));

  // R6: a fresh request survives a clear in the same cycle
  a_r6_request_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> ((pend_q & $past(req)) == $past(req)));

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned NCH = 10
) (
  input  logic [NCH-1:0] cand,
  output logic [NCH-1:0] win
);

  always_comb begin
    win = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (cand[c]) begin
        win    = '0;
        win[c] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_cascade_net.sv
module dma_cascade_net
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH          = DMA_NCH,
  parameter int unsigned RING_MASK_CH = 9,
  parameter int unsigned UF_MASK_CH   = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           done_fire,
  input  logic           uflow,
  input  logic [NCH-1:0] grant,
  input  logic           ring_we,
  input  logic           uf_we,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] casc_xf,
  output logic [NCH-1:0] casc_uf
);

  logic [NCH-1:0] ring_mask_q, uf_mask_q;
  logic [NCH-1:0] xf_row [NCH];
  logic [NCH-1:0] uf_row [NCH];
  logic [NCH-1:0] xf_tgt, uf_tgt;
  logic [NCH-1:0] xf_d, uf_d, xf_q, uf_q;
  logic           pulse_upd;

  for (genvar c = 0; c < NCH; c++) begin : g_row
    if (c == RING_MASK_CH) begin : g_xf_prog
      assign xf_row[c] = grant[c] ? ring_mask_q : '0;
    end else begin : g_xf_fix
      assign xf_row[c] = grant[c] ? xfer_targets(c) : '0;
    end
    if (c == UF_MASK_CH) begin : g_uf_prog
      assign uf_row[c] = grant[c] ? uf_mask_q : '0;
    end else begin : g_uf_fix
      assign uf_row[c] = grant[c] ? uflow_targets(c) : '0;
    end
  end

  always_comb begin
    xf_tgt = '0;
    uf_tgt = '0;
    for (int c = 0; c < NCH; c++) begin
      xf_tgt = xf_tgt | xf_row[c];
      uf_tgt = uf_tgt | uf_row[c];
    end
    xf_d      = done_fire ? xf_tgt : '0;
    uf_d      = (done_fire && uflow) ? uf_tgt : '0;
    pulse_upd = (xf_d != xf_q) || (uf_d != uf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xf_q <= '0;
      uf_q <= '0;
    end else if (pulse_upd) begin
      xf_q <= xf_d;
      uf_q <= uf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ring_mask_q <= '0;
    else if (ring_we) ring_mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     uf_mask_q <= '0;
    else if (uf_we) uf_mask_q <= wdata;
  end

  assign casc_xf = xf_q;
  assign casc_uf = uf_q;

  // R7: per-transfer cascade pulses last a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (xf_q != '0) |=> (xf_q == '0));

  // R8: underflow pulses last a single cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_q != '0) |=> (uf_q == '0));

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int unsigned NCH          = DMA_NCH,
  parameter int unsigned RING_MASK_CH = 9,
  parameter int unsigned UF_MASK_CH   = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           ch_en,
  input  logic [DMA_SEL_W*NCH-1:0] src_sel,
  input  logic [NCH-1:0]           sw_trig,
  input  logic [NCH-1:0]           periph_req,
  input  logic                     xfer_done,
  input  logic                     xfer_uflow,
  input  logic                     ring_mask_we,
  input  logic                     uf_mask_we,
  input  logic [NCH-1:0]           mask_wdata,
  output logic [NCH-1:0]           grant,
  output logic [NCH-1:0]           casc_xfer_go,
  output logic [NCH-1:0]           casc_uflow_go
);

  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  arb_rst_n;
  logic [NCH-1:0]        req_v, pend_v, pick_v, clr_v;
  logic [NCH-1:0]        grant_q, grant_d;
  logic [NCH-1:0]        xf_v, uf_v;
  logic                  busy, done_fire, grant_upd;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign arb_rst_n = rst_pipe[RST_STAGES-1];

  dma_src_mux #(.NCH(NCH)) src_i (
    .ch_en(ch_en), .src_sel(src_sel), .sw_trig(sw_trig),
    .periph_req(periph_req), .casc_xf(xf_v), .casc_uf(uf_v), .req(req_v)
  );

  dma_pend_latch #(.NCH(NCH)) pend_i (
    .clk(clk), .rst_n(arb_rst_n), .req(req_v), .clr(clr_v),
    .ch_en(ch_en), .pend(pend_v)
  );

  dma_prio_pick #(.NCH(NCH)) pick_i (.cand(pend_v), .win(pick_v));

  dma_cascade_net #(
    .NCH(NCH), .RING_MASK_CH(RING_MASK_CH), .UF_MASK_CH(UF_MASK_CH)
  ) casc_i (
    .clk(clk), .rst_n(arb_rst_n), .done_fire(done_fire), .uflow(xfer_uflow),
    .grant(grant_q), .ring_we(ring_mask_we), .uf_we(uf_mask_we),
    .wdata(mask_wdata), .casc_xf(xf_v), .casc_uf(uf_v)
  );

  always_comb begin
    busy      = (grant_q != '0);
    done_fire = busy && xfer_done;
    clr_v     = done_fire ? grant_q : '0;
    if (busy) grant_d = xfer_done ? '0 : grant_q;
    else      grant_d = pick_v;
    grant_upd = (grant_d != grant_q);
  end

  always_ff @(posedge clk or negedge arb_rst_n) begin
    if (!arb_rst_n)     grant_q <= '0;
    else if (grant_upd) grant_q <= grant_d;
  end

  assign grant         = grant_q;
  assign casc_xfer_go  = xf_v;
  assign casc_uflow_go = uf_v;

  // R4: never more than one channel owns the bus
  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!arb_rst_n)
    $onehot0(grant_q));

  // R4: grant held until the transfer reports done
  a_r4_grant_hold: assert property (@(posedge clk) disable iff (!arb_rst_n)
    (busy && !xfer_done) |=> $stable(grant_q));

  // R4: bus released right after done
  a_r4_release: assert property (@(posedge clk) disable iff (!arb_rst_n)
    (busy && xfer_done) |=> (grant_q == '0));

  // R3: a new grant goes to a pending channel with none of lower index pending
  a_r3_fixed_priority: assert property (@(posedge clk) disable iff (!arb_rst_n)
    $rose(busy) |-> (((grant_q & $past(pend_v)) != '0) &&
                     (((grant_q - NCH'(1)) & $past(pend_v)) == '0)));

  // R11: done without a grant produces no cascade pulse
  a_r11_idle_done: assert property (@(posedge clk) disable iff (!arb_rst_n)
    (!busy && xfer_done) |=> ((xf_v == '0) && (uf_v == '0)));

endmodule

// File: tb/dma_req_arbiter_tb_top.sv
module dma_req_arbiter_tb_top;

  localparam int unsigned NCH        = 10;
  localparam time         CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   ch_en = '0;
  logic [2*NCH-1:0] src_sel = '0;
  logic [NCH-1:0]   sw_trig = '0;
  logic [NCH-1:0]   periph_req = '0;
  logic             xfer_done = 1'b0;
  logic             xfer_uflow = 1'b0;
  logic             ring_mask_we = 1'b0;
  logic             uf_mask_we = 1'b0;
  logic [NCH-1:0]   mask_wdata = '0;
  logic [NCH-1:0]   grant, casc_xfer_go, casc_uflow_go;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_req_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .src_sel(src_sel),
    .sw_trig(sw_trig), .periph_req(periph_req), .xfer_done(xfer_done),
    .xfer_uflow(xfer_uflow), .ring_mask_we(ring_mask_we),
    .uf_mask_we(uf_mask_we), .mask_wdata(mask_wdata), .grant(grant),
    .casc_xfer_go(casc_xfer_go), .casc_uflow_go(casc_uflow_go)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [NCH-1:0] exp_xf(input int c, input logic [NCH-1:0] ring);
    if (c < 3)                  return NCH'(1) << ((c + 1) % 3);
    else if (c == 3)            return NCH'(1) << 4;
    else if (c >= 5 && c <= 7)  return NCH'(1) << (5 + (c - 4) % 3);
    else if (c == 8)            return NCH'(1) << 9;
    else if (c == 9)            return ring;
    return '0;
  endfunction

  function automatic logic [NCH-1:0] exp_uf(input int c, input logic [NCH-1:0] ufm);
    if (c == 0)      return NCH'(1) << 5;
    else if (c == 3) return NCH'(1) << 8;
    else if (c == 1) return ufm;
    return '0;
  endfunction

  function automatic int idx_of(input logic [NCH-1:0] v);
    for (int c = 0; c < NCH; c++) if (v[c]) return c;
    return 0;
  endfunction

  // Cycle model built from the requirements.
  logic [NCH-1:0] m_pend, m_grant, m_xf, m_uf, m_ring, m_ufm;
  always @(posedge clk or negedge rst_n) begin : model
    logic [NCH-1:0] rq, cl, pk;
    logic           hit;
    if (!rst_n) begin
      m_pend <= '0; m_grant <= '0; m_xf <= '0; m_uf <= '0;
      m_ring <= '0; m_ufm <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        case (src_sel[2*c +: 2])
          2'd0:    hit = sw_trig[c];
          2'd1:    hit = periph_req[c];
          2'd2:    hit = m_xf[c];
          default: hit = m_uf[c];
        endcase
        rq[c] = ch_en[c] & hit;
      end
      cl = ((m_grant != '0) && xfer_done) ? m_grant : '0;
      m_pend <= ((m_pend & ~cl) | rq) & ch_en;
      m_xf <= '0;
      m_uf <= '0;
      if (m_grant != '0) begin
        if (xfer_done) begin
          m_grant <= '0;
          m_xf <= exp_xf(idx_of(m_grant), m_ring);
          m_uf <= xfer_uflow ? exp_uf(idx_of(m_grant), m_ufm) : '0;
        end
      end else begin
        pk = '0;
        for (int c = NCH - 1; c >= 0; c--) if (m_pend[c]) pk = NCH'(1) << c;
        m_grant <= pk;
      end
      if (ring_mask_we) m_ring <= mask_wdata;
      if (uf_mask_we)   m_ufm  <= mask_wdata;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      chk(grant == m_grant, "R3/R4 model grant", 32'(grant), 32'(m_grant));
      chk(casc_xfer_go == m_xf, "R7/R9 model xfer pulse", 32'(casc_xfer_go), 32'(m_xf));
      chk(casc_uflow_go == m_uf, "R8/R9 model uflow pulse", 32'(casc_uflow_go), 32'(m_uf));
    end
  end

  task automatic report();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_all_sel(input logic [1:0] s);
    for (int c = 0; c < NCH; c++) src_sel[2*c +: 2] = s;
  endtask

  // Serve channel c once, checking its grant and cascade outputs.
  task automatic cascade_case(input int c, input bit u);
    sw_trig = NCH'(1) << c; step(); sw_trig = '0; step();
    chk(grant == (NCH'(1) << c), "R3 single grant", 32'(grant), 32'(NCH'(1) << c));
    step(2);
    chk(grant == (NCH'(1) << c), "R4 grant held", 32'(grant), 32'(NCH'(1) << c));
    xfer_done = 1'b1; xfer_uflow = u; step(); xfer_done = 1'b0; xfer_uflow = 1'b0;
    chk(grant == '0, "R4 release", 32'(grant), 0);
    chk(casc_xfer_go == exp_xf(c, m_ring), "R7 xfer targets",
        32'(casc_xfer_go), 32'(exp_xf(c, m_ring)));
    chk(casc_uflow_go == (u ? exp_uf(c, m_ufm) : '0), "R8 uflow targets",
        32'(casc_uflow_go), 32'(u ? exp_uf(c, m_ufm) : '0));
    step();
    chk(casc_xfer_go == '0 && casc_uflow_go == '0, "R7 pulse one cycle",
        32'(casc_xfer_go | casc_uflow_go), 0);
    chk(grant == '0, "R2 cascade ignored by soft select", 32'(grant), 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog expired actual=running expected=done");
      report();
    end
  end

  initial begin : main
    logic [NCH-1:0] rem, lb;
    step(2);
    rst_n = 1'b1;
    step(4);
    // R1: reset state
    chk(grant == '0, "R1 grant", 32'(grant), 0);
    chk(casc_xfer_go == '0 && casc_uflow_go == '0, "R1 pulses",
        32'(casc_xfer_go | casc_uflow_go), 0);
    cmp_on = 1'b1;

    // R11: done with no grant
    xfer_done = 1'b1; xfer_uflow = 1'b1; step(); xfer_done = 1'b0; xfer_uflow = 1'b0;
    chk(casc_xfer_go == '0 && casc_uflow_go == '0, "R11 idle done",
        32'(casc_xfer_go | casc_uflow_go), 0);
    step();
    chk(grant == '0, "R11 no grant", 32'(grant), 0);

    // R7/R8/R9: cascade maps with masks at reset value, then loaded
    ch_en = '1; set_all_sel(2'd0);
    for (int c = 0; c < NCH; c++)
      for (int u = 0; u < 2; u++) cascade_case(c, u[0]);
    mask_wdata = 10'h2A5; ring_mask_we = 1'b1; step(); ring_mask_we = 1'b0;
    mask_wdata = 10'h15A; uf_mask_we = 1'b1; step(); uf_mask_we = 1'b0;
    mask_wdata = '0;
    for (int c = 0; c < NCH; c++)
      for (int u = 0; u < 2; u++) cascade_case(c, u[0]);

    // R3: every pattern of simultaneous software requests
    for (int p = 1; p < (1 << NCH); p++) begin
      sw_trig = NCH'(p); step(); sw_trig = '0; step();
      rem = NCH'(p);
      while (rem != '0) begin
        lb = rem & (~rem + NCH'(1));
        chk(grant == lb, "R3 priority order", 32'(grant), 32'(lb));
        xfer_done = 1'b1; step(); xfer_done = 1'b0;
        chk(grant == '0, "R4 gap after done", 32'(grant), 0);
        rem = rem & ~lb;
        step();
      end
      chk(grant == '0, "R5 no extra grant", 32'(grant), 0);
    end

    // R2: enable and source selection
    ch_en = '1; ch_en[2] = 1'b0;
    sw_trig = 10'h004; step(); sw_trig = '0; step(2);
    chk(grant == '0, "R2 disabled channel", 32'(grant), 0);
    ch_en[2] = 1'b1; src_sel[5:4] = 2'd1;
    sw_trig = 10'h004; step(); sw_trig = '0; step(2);
    chk(grant == '0, "R2 soft trigger ignored on peripheral select", 32'(grant), 0);
    periph_req = 10'h008; step(); periph_req = '0; step(2);
    chk(grant == '0, "R2 peripheral ignored on soft select", 32'(grant), 0);
    periph_req = 10'h004; step(); periph_req = '0; step();
    chk(grant == 10'h004, "R2 peripheral request", 32'(grant), 32'h004);
    xfer_done = 1'b1; step(); xfer_done = 1'b0; step();
    src_sel[5:4] = 2'd0;

    // R5: merged requests
    sw_trig = 10'h010; step(); step(); sw_trig = '0;
    chk(grant == 10'h010, "R5 grant", 32'(grant), 32'h010);
    xfer_done = 1'b1; step(); xfer_done = 1'b0; step(3);
    chk(grant == '0, "R5 merged once", 32'(grant), 0);

    // R6: request in the same cycle as done
    sw_trig = 10'h010; step(); sw_trig = '0; step();
    xfer_done = 1'b1; sw_trig = 10'h010; step(); xfer_done = 1'b0; sw_trig = '0;
    chk(grant == '0, "R6 released", 32'(grant), 0);
    step();
    chk(grant == 10'h010, "R6 regrant", 32'(grant), 32'h010);
    xfer_done = 1'b1; step(); xfer_done = 1'b0; step();

    // R10: 8 -> 9 -> 9 self cascade through the mask
    mask_wdata = 10'h200; ring_mask_we = 1'b1; step(); ring_mask_we = 1'b0;
    src_sel[19:18] = 2'd2;
    sw_trig = 10'h100; step(); sw_trig = '0; step();
    chk(grant == 10'h100, "R10 ch8 grant", 32'(grant), 32'h100);
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
    chk(casc_xfer_go == 10'h200, "R10 pulse to ch9", 32'(casc_xfer_go), 32'h200);
    step();
    chk(grant == '0, "R10 not same cycle", 32'(grant), 0);
    step();
    chk(grant == 10'h200, "R10 ch9 grant", 32'(grant), 32'h200);
    xfer_done = 1'b1; step(); xfer_done = 1'b0;
    chk(casc_xfer_go == 10'h200, "R9 self mask", 32'(casc_xfer_go), 32'h200);
    step(2);
    chk(grant == 10'h200, "R10 self regrant", 32'(grant), 32'h200);
    xfer_done = 1'b1; ch_en[9] = 1'b0; step(); xfer_done = 1'b0; step(3);
    chk(grant == '0, "R2 disable stops ring", 32'(grant), 0);

    // Random phase judged by the model
    for (int k = 0; k < 4000; k++) begin
      for (int c = 0; c < NCH; c++) begin
        ch_en[c] = ($urandom % 10) != 0;
        if (($urandom % 16) == 0) src_sel[2*c +: 2] = 2'($urandom);
      end
      sw_trig      = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
      periph_req   = NCH'($urandom) & NCH'($urandom);
      xfer_done    = ($urandom % 3) == 0;
      xfer_uflow   = $urandom % 2;
      mask_wdata   = NCH'($urandom);
      ring_mask_we = ($urandom % 64) == 0;
      uf_mask_we   = ($urandom % 64) == 0;
      step();
    end
    sw_trig = '0; periph_req = '0; ring_mask_we = 1'b0; uf_mask_we = 1'b0;
    ch_en = '0; xfer_done = 1'b1; step(3); xfer_done = 1'b0; step(2);
    chk(grant == '0, "R2 all disabled", 32'(grant), 0);
    report();
  end

endmodule